// File: doc/BRIEF.md
# Deferred Two-Stage Result Commit

This block lets an arithmetic instruction retire in the clock it issues, while the register-file write of its result happens later. At issue, the operands, the opcode and the absolute destination index go into stage registers. The result is then produced by a front phase and a back phase. The front phase detects special operands and does the add, subtract, multiply or move. The back phase rounds and packs. The finished value leaves on a dedicated absolute-index write port.

A compile-time parameter sets the pipeline depth. With depth 1, both phases run in the clock after issue. With depth 2, a mid-stage register separates the two phases, and the write happens two clocks after issue. Either depth is within the three-clock latency at which a dependent instruction may read the result, so dependent chains keep their cycle counts. The only thing that moves is where the long combinational path sits in time.

Stages advance on every clock, and a new op may enter on every clock. Any read index that names the target of a valid in-flight stage raises a stall output. This keeps a reader from seeing the stale value that exists before the deferred write lands.

Top module: `fp_defer_commit`

## Requirements
- R1: While reset is asserted, and after its release until an op is issued, `wr_en` and `hz_stall` stay low.
- R2: An op can be accepted on every clock without back-pressure, and every op issued with `iss_vld` high produces exactly one write.
- R3: With DEPTH=1, an op issued at clock edge N drives `wr_en` high with `wr_idx` equal to its destination during the cycle that follows edge N, so the write lands at edge N+1.
- R4: With DEPTH=2, the write for an op issued at edge N is presented during the cycle after edge N+1 and lands at edge N+2. This is still before the dependent-read point at N+3.
- R5: The opcode encodings are 0 add, 1 subtract, 2 multiply and 3 move-a. The front phase forms a DW+1-bit intermediate: a+b, a-b modulo 2^(DW+1), the low DW+1 bits of a*b, or a shifted left by one, respectively.
- R6: If either operand is all ones, the result is all ones, whatever the opcode.
- R7: In the back phase, the intermediate is halved with round-half-up, modulo 2^DW, so that `wr_data` = (w+1)>>1 truncated to DW bits.
- R8: `hz_stall` is high in any cycle where some valid stage, at either depth position, has a destination equal to any read index. Read port k occupies bits `rd_idx[k*IW +: IW]`.
- R9: `hz_stall` is low when no valid stage's destination matches any read index. Stages that are not valid never cause a stall.
- R10: For the same issue sequence, DEPTH=2 writes the same data values as DEPTH=1, each one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_vld | input | 1 | An op issues (and retires) this clock |
| iss_op | input | 2 | Opcode: 0 add, 1 sub, 2 mul, 3 move |
| iss_a | input | DW | First operand |
| iss_b | input | DW | Second operand |
| iss_dst | input | IW | Absolute destination register index |
| rd_idx | input | NRD*IW | Register indices being read this cycle, packed per port |
| hz_stall | output | 1 | A read index matches an in-flight target |
| wr_en | output | 1 | Deferred write enable |
| wr_idx | output | IW | Deferred write absolute index |
| wr_data | output | DW | Deferred write value |

## Verification
The hardest case to reach is a hazard on the older stage alone: the stage-1 target has to be read while stage 0 holds a different, valid target, with a read on the other port at the same moment. Reaching it requires back-to-back issues to distinct registers, with the read indices steered one cycle later. Directed sequences set this up, and the same sequences also swap which port carries the match. A long random phase then follows, with dense issue, narrow index ranges and frequent all-ones operands. Both depths run side by side against a behavioural queue model, so the one-clock shift between their data streams is checked on every write.

// File: rtl/fp_defer_commit.sv
module fp_defer_commit #(
  parameter int DW    = 32,
  parameter int IW    = 3,
  parameter int NRD   = 2,
  parameter int DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_vld,
  input  logic [1:0]        iss_op,
  input  logic [DW-1:0]     iss_a,
  input  logic [DW-1:0]     iss_b,
  input  logic [IW-1:0]     iss_dst,
  input  logic [NRD*IW-1:0] rd_idx,
  output logic              hz_stall,
  output logic              wr_en,
  output logic [IW-1:0]     wr_idx,
  output logic [DW-1:0]     wr_data
);
  localparam int MW = DW + 2;
  typedef logic [MW-1:0] mid_t;

  function automatic mid_t phase_front(input logic [1:0] op,
                                       input logic [DW-1:0] a,
                                       input logic [DW-1:0] b);
    logic [2*DW-1:0] prod;
    logic [DW:0]     w;
    logic            spec;
    prod = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
    spec = (&a) | (&b);
    case (op)
      2'd0:    w = {1'b0, a} + {1'b0, b};
      2'd1:    w = {1'b0, a} - {1'b0, b};
      2'd2:    w = prod[DW:0];
      default: w = {a, 1'b0};
    endcase
    return {spec, w};
  endfunction

  function automatic logic [DW-1:0] phase_back(input mid_t m);
    return m[MW-1] ? '1 : m[DW:1] + DW'(m[0]);
  endfunction

  logic            s0_v;
  logic [1:0]      s0_op;
  logic [DW-1:0]   s0_a, s0_b;
  logic [IW-1:0]   s0_dst;
  logic [DEPTH-1:0] st_v;
  logic [IW-1:0]   st_dst [DEPTH];
  mid_t            cmt_mid;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) s0_v <= 1'b0;
    else        s0_v <= iss_vld;

  always_ff @(posedge clk)
    if (iss_vld) begin
      s0_op  <= iss_op;
      s0_a   <= iss_a;
      s0_b   <= iss_b;
      s0_dst <= iss_dst;
    end

  assign st_v[0]   = s0_v;
  assign st_dst[0] = s0_dst;

  generate
    if (DEPTH == 1) begin : g_one
      assign cmt_mid = phase_front(s0_op, s0_a, s0_b);
      assign wr_en   = s0_v;
      assign wr_idx  = s0_dst;
    end else begin : g_two
      logic          s1_v;
      logic [IW-1:0] s1_dst;
      mid_t          s1_mid;

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) s1_v <= 1'b0;
        else        s1_v <= s0_v;

      always_ff @(posedge clk)
        if (s0_v) begin
          s1_dst <= s0_dst;
          s1_mid <= phase_front(s0_op, s0_a, s0_b);
        end

      assign st_v[1]   = s1_v;
      assign st_dst[1] = s1_dst;
      assign cmt_mid   = s1_mid;
      assign wr_en     = s1_v;
      assign wr_idx    = s1_dst;
    end
  endgenerate

  assign wr_data = phase_back(cmt_mid);

  always_comb begin
    hz_stall = 1'b0;
    for (int s = 0; s < DEPTH; s++)
      for (int k = 0; k < NRD; k++)
        if (st_v[s] && rd_idx[k*IW +: IW] == st_dst[s]) hz_stall = 1'b1;
  end
endmodule

// File: rtl/fp_defer_commit_chk.sv
module fp_defer_commit_chk #(
  parameter int DW    = 32,
  parameter int IW    = 3,
  parameter int NRD   = 2,
  parameter int DEPTH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iss_vld,
  input logic [IW-1:0]     iss_dst,
  input logic [NRD*IW-1:0] rd_idx,
  input logic              hz_stall,
  input logic              wr_en,
  input logic [IW-1:0]     wr_idx
);
  function automatic logic rd_hit(input logic [IW-1:0] idx);
    logic h;
    h = 1'b0;
    for (int k = 0; k < NRD; k++)
      if (rd_idx[k*IW +: IW] == idx) h = 1'b1;
    return h;
  endfunction

  logic          p1_v, p2_v;
  logic [IW-1:0] p1_dst, p2_dst;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      p1_v <= 1'b0; p2_v <= 1'b0; p1_dst <= '0; p2_dst <= '0;
    end else begin
      p1_v <= iss_vld; p2_v <= p1_v; p1_dst <= iss_dst; p2_dst <= p1_dst;
    end

  always @(negedge clk)
    if (!rst_n) AST_RESET_IDLE: assert (!wr_en && !hz_stall); // R1

  AST_WRITE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_hit(wr_idx)) |-> hz_stall); // R8

  AST_STAGE0_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_v && rd_hit(p1_dst)) |-> hz_stall); // R8

  generate
    if (DEPTH == 1) begin : g_a1
      AST_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |=> wr_en); // R3
      AST_INDEX_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |=> (wr_idx == $past(iss_dst))); // R3
      AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_vld |=> !wr_en); // R2
      AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        hz_stall |-> (p1_v && rd_hit(p1_dst))); // R9
    end else begin : g_a2
      AST_WRITE_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |=> ##1 wr_en); // R4
      AST_INDEX_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |=> ##1 (wr_idx == $past(iss_dst, 2))); // R4
      AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_vld |=> ##1 !wr_en); // R2
      AST_STAGE1_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (p2_v && rd_hit(p2_dst)) |-> hz_stall); // R8
      AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        hz_stall |-> ((p1_v && rd_hit(p1_dst)) || (p2_v && rd_hit(p2_dst)))); // R9
    end
  endgenerate
endmodule

bind fp_defer_commit fp_defer_commit_chk #(.DW(DW), .IW(IW), .NRD(NRD), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_dst(iss_dst), .rd_idx(rd_idx),
  .hz_stall(hz_stall), .wr_en(wr_en), .wr_idx(wr_idx)
);

// File: tb/fp_defer_commit_tb_top.sv
module fp_defer_commit_tb_top;
  localparam int DW = 32, IW = 3, NRD = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic iss_vld = 1'b0;
  logic [1:0] iss_op = '0;
  logic [DW-1:0] iss_a = '0, iss_b = '0;
  logic [IW-1:0] iss_dst = '0;
  logic [NRD*IW-1:0] rd_idx = '0;
  logic hz2, en2, hz1, en1;
  logic [IW-1:0] idx2, idx1;
  logic [DW-1:0] dat2, dat1;

  always #10 clk = ~clk;

  fp_defer_commit #(.DW(DW), .IW(IW), .NRD(NRD), .DEPTH(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_op(iss_op), .iss_a(iss_a),
    .iss_b(iss_b), .iss_dst(iss_dst), .rd_idx(rd_idx), .hz_stall(hz2),
    .wr_en(en2), .wr_idx(idx2), .wr_data(dat2));

  fp_defer_commit #(.DW(DW), .IW(IW), .NRD(NRD), .DEPTH(1)) dut1_i (
    .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_op(iss_op), .iss_a(iss_a),
    .iss_b(iss_b), .iss_dst(iss_dst), .rd_idx(rd_idx), .hz_stall(hz1),
    .wr_en(en1), .wr_idx(idx1), .wr_data(dat1));

  typedef struct { bit v; logic [IW-1:0] d; logic [DW-1:0] x; string tag; } ent_t;
  ent_t q2[$], q1[$];
  int nchk = 0, nfail = 0, n_iss = 0, n_wr2 = 0, n_wr1 = 0;
  bit prev1_v = 0;
  logic [DW-1:0] prev1_x;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  function automatic ent_t model(bit v, logic [1:0] op, logic [DW-1:0] a,
                                 logic [DW-1:0] b, logic [IW-1:0] d);
    ent_t e;
    logic [63:0] w, m;
    m = (64'd1 << (DW + 1)) - 1;
    case (op)
      2'd0: w = 64'(a) + 64'(b);
      2'd1: w = 64'(a) - 64'(b);
      2'd2: w = 64'(a) * 64'(b);
      default: w = 64'(a) * 2;
    endcase
    w = w & m;
    e.v = v; e.d = d;
    if (a == '1 || b == '1) begin e.x = '1; e.tag = "R6"; end
    else begin
      e.x = DW'((w + 1) >> 1);
      e.tag = w[0] ? "R7" : "R5";
    end
    return e;
  endfunction

  function automatic bit hit(logic [IW-1:0] d);
    bit h = 0;
    for (int k = 0; k < NRD; k++) if (rd_idx[k*IW +: IW] == d) h = 1;
    return h;
  endfunction

  task automatic compare();
    bit eh2 = 0, eh1 = 0;
    foreach (q2[i]) if (q2[i].v && hit(q2[i].d)) eh2 = 1;
    foreach (q1[i]) if (q1[i].v && hit(q1[i].d)) eh1 = 1;
    check(eh2 ? "R8 depth2" : "R9 depth2", 64'(hz2), 64'(eh2));
    check(eh1 ? "R8 depth1" : "R9 depth1", 64'(hz1), 64'(eh1));
    check("R4 wr_en", 64'(en2), 64'(q2[0].v));
    check("R3 wr_en", 64'(en1), 64'(q1[0].v));
    if (q2[0].v && en2) begin
      n_wr2++;
      check("R4 wr_idx", 64'(idx2), 64'(q2[0].d));
      check({q2[0].tag, " depth2 data"}, 64'(dat2), 64'(q2[0].x));
      if (prev1_v) check("R10 depth match", 64'(dat2), 64'(prev1_x));
    end
    prev1_v = 0;
    if (q1[0].v && en1) begin
      n_wr1++;
      check("R3 wr_idx", 64'(idx1), 64'(q1[0].d));
      check({q1[0].tag, " depth1 data"}, 64'(dat1), 64'(q1[0].x));
      prev1_v = 1; prev1_x = dat1;
    end
  endtask

  task automatic step(bit v, logic [1:0] op, logic [DW-1:0] a, logic [DW-1:0] b,
                      logic [IW-1:0] d, logic [IW-1:0] r0, logic [IW-1:0] r1);
    ent_t e;
    iss_vld = v; iss_op = op; iss_a = a; iss_b = b; iss_dst = d;
    rd_idx = {r1, r0};
    #1 compare();
    e = model(v, op, a, b, d);
    if (v) n_iss++;
    @(posedge clk);
    void'(q2.pop_front()); q2.push_back(e);
    void'(q1.pop_front()); q1.push_back(e);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    ent_t z;
    z.v = 0; z.d = '0; z.x = '0; z.tag = "";
    q2.push_back(z); q2.push_back(z); q1.push_back(z);
    repeat (3) begin
      @(negedge clk);
      rd_idx = '0;
      check("R1 reset wr_en", 64'({en2, en1}), 64'd0);
      check("R1 reset stall", 64'({hz2, hz1}), 64'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 0, 0, 0, 0, 0, 0);
    check("R1 idle after reset", 64'({en2, en1, hz2, hz1}), 64'd0);
    // directed ops
    step(1, 0, 32'd10, 32'd20, 3'd1, 3'd7, 3'd7);
    step(1, 1, 32'd3, 32'd5, 3'd2, 3'd1, 3'd6);      // R8 stage0 hit on port0
    step(1, 2, 32'h0001_0003, 32'h0002_0001, 3'd3, 3'd5, 3'd1); // R8 stage1 hit on port1
    step(1, 3, 32'h1234_5678, 32'd0, 3'd4, 3'd0, 3'd0);
    step(1, 0, 32'hFFFF_FFFF, 32'd1, 3'd5, 3'd6, 3'd6);  // R6
    step(1, 2, 32'd7, 32'hFFFF_FFFF, 3'd6, 3'd0, 3'd0);  // R6
    step(1, 0, 32'd4, 32'd3, 3'd0, 3'd6, 3'd5);          // R7 odd intermediate
    step(1, 0, 32'hFFFF_FFFE, 32'hFFFF_FFFE, 3'd7, 3'd2, 3'd3);
    step(0, 0, 0, 0, 0, 3'd7, 3'd0);
    step(0, 0, 0, 0, 0, 3'd7, 3'd7);
    step(0, 0, 0, 0, 0, 3'd7, 3'd7);                     // R9 nothing in flight
    // same target twice, then gaps
    step(1, 1, 32'd0, 32'd1, 3'd2, 3'd4, 3'd4);
    step(1, 1, 32'd9, 32'd1, 3'd2, 3'd2, 3'd4);
    step(0, 0, 0, 0, 0, 3'd4, 3'd2);
    step(1, 3, 32'hDEAD_BEEF, 32'd0, 3'd3, 3'd2, 3'd2);
    step(0, 0, 0, 0, 0, 3'd3, 3'd2);
    step(0, 0, 0, 0, 0, 3'd0, 3'd0);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [DW-1:0] a, b;
      a = ($urandom_range(0, 7) == 0) ? '1 : DW'($urandom);
      b = ($urandom_range(0, 7) == 0) ? '1 : DW'($urandom_range(0, 1000));
      step($urandom_range(0, 3) != 0, 2'($urandom), a, b,
           IW'($urandom_range(0, 3)), IW'($urandom_range(0, 7)), IW'($urandom_range(0, 3)));
    end
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    check("R2 depth2 writes equal issues", 64'(n_wr2), 64'(n_iss));
    check("R2 depth1 writes equal issues", 64'(n_wr1), 64'(n_iss));
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule